// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by reading two levels of translation tables from memory. The top ten address bits pick an entry in the directory, the next ten pick an entry in the page table, and the low twelve bits are the byte offset within a 4 KB page. Each level has 1024 four-byte entries. The directory's frame number comes from a base register input. Each entry read goes out on a memory read port that holds a request until it is granted and then waits for a data-valid response.

Every entry that comes back is checked against the access. A missing entry, a write to a read-only entry, or a user access to a supervisor entry ends the walk with a one-cycle fault strobe and a cause code. The faulting linear address is also captured in a register. A successful walk gives a one-cycle done strobe and the physical address. When paging or protected mode is off, the block passes the linear address through unchanged and reads no memory.

Top module: `pt_walker`

## Requirements
- R1: During reset `done_o`, `fault_o` and `mem_req_o` are 0, `req_ready_o` is 1, and `fault_addr_o` is 0.
- R2: If `paging_en_i` and `prot_en_i` are not both 1 when a request is accepted, `done_o` pulses on the next cycle with `paddr_o` equal to the linear address, and `mem_req_o` never rises.
- R3: When translation is on, `mem_req_o` rises in the cycle after acceptance with address `{dir_frame_i, laddr[31:22], 2'b00}`. The request and its address stay unchanged until a cycle in which `mem_gnt_i` is 1, and drop after that cycle.
- R4: After a directory entry passes its checks, the next read goes to `{dir_entry[31:12], laddr[21:12], 2'b00}`. This request follows the same hold rule as R3.
- R5: After the table entry passes its checks, `done_o` is 1 in the cycle after `mem_rvalid_i`, and `paddr_o = {table_entry[31:12], laddr[11:0]}`.
- R6: An entry at either level with bit 0 (present) equal to 0 raises `fault_o` with `fault_cause_o = 1` and loads `fault_addr_o` with the linear address. A directory fault issues no table read.
- R7: A write access (`req_write_i = 1`) to an entry with bit 1 equal to 0 raises a fault with cause 2, at either level.
- R8: A user access (`req_user_i = 1`) to an entry with bit 2 equal to 0 raises a fault with cause 3. When several checks fail, the priority is present, then write, then user.
- R9: A request is accepted only while `req_ready_o` is 1, which is only when the walker is idle; `req_valid_i` at other times is ignored. `done_o` and `fault_o` each last exactly one cycle and are never 1 together.
- R10: Entry bits 5 (accessed) and 7 (page size) have no effect on translation or checks.
- R11: `fault_addr_o` changes only in a cycle where `fault_o` is 1. A successful walk leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request is taken |
| req_laddr_i | input | 32 | Linear address |
| req_write_i | input | 1 | Access is a write |
| req_user_i | input | 1 | Access is from user mode |
| paging_en_i | input | 1 | Paging enable |
| prot_en_i | input | 1 | Protected-mode enable |
| dir_frame_i | input | 20 | Directory base frame number (physical bits 31..12) |
| mem_req_o | output | 1 | Entry read request |
| mem_gnt_i | input | 1 | Read request taken |
| mem_addr_o | output | 32 | Entry byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry read data |
| done_o | output | 1 | Translation complete strobe |
| paddr_o | output | 32 | Physical address |
| fault_o | output | 1 | Fault strobe |
| fault_cause_o | output | 2 | 1 not present, 2 write denied, 3 user denied |
| fault_addr_o | output | 32 | Last faulting linear address |

## Verification
In bypass, the done strobe comes one clock after the accepting edge. With translation on, the directory read request is seen right after that same edge. Each further read request appears right after the edge that took the previous response, and the done or fault strobe appears one clock after the final `mem_rvalid_i`. The bench drives every handshake itself on the cycle after a rising edge, so it knows which edge each result belongs to. It checks the result values just after that edge and compares both strobes against its own model on every falling edge. Grant and response delays are varied, and a stray request is driven while the walker is busy.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DREQ,
    ST_DWAIT,
    ST_TREQ,
    ST_TWAIT
  } walk_st_e;

  localparam logic [1:0] FC_NONE   = 2'd0;
  localparam logic [1:0] FC_ABSENT = 2'd1;
  localparam logic [1:0] FC_WRITE  = 2'd2;
  localparam logic [1:0] FC_USER   = 2'd3;

  localparam int ENT_PRESENT = 0;
  localparam int ENT_WRITE   = 1;
  localparam int ENT_USER    = 2;
  localparam int LEVELS      = 2;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int ADDR_W = 2 * IDX_W + OFF_W,
  localparam int FRAME_W = ADDR_W - OFF_W
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [ADDR_W-1:0]  addr_o
);
  // four bytes per entry
  assign addr_o = {frame_i, OFF_W'(0)} | (ADDR_W'(idx_i) << 2);
endmodule

// File: rtl/pw_perm_check.sv
module pw_perm_check
  import pt_walker_pkg::*;
(
  input  logic       present_i,
  input  logic       wr_ok_i,
  input  logic       user_ok_i,
  input  logic       write_i,
  input  logic       user_i,
  output logic [1:0] cause_o
);
  always_comb begin
    if (!present_i)              cause_o = FC_ABSENT;
    else if (write_i && !wr_ok_i) cause_o = FC_WRITE;
    else if (user_i && !user_ok_i) cause_o = FC_USER;
    else                          cause_o = FC_NONE;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int IDX_W = 10,
  parameter int OFF_W = 12,
  localparam int ADDR_W = 2 * IDX_W + OFF_W,
  localparam int FRAME_W = ADDR_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [ADDR_W-1:0]  req_laddr_i,
  input  logic               req_write_i,
  input  logic               req_user_i,
  input  logic               paging_en_i,
  input  logic               prot_en_i,
  input  logic [FRAME_W-1:0] dir_frame_i,
  output logic               mem_req_o,
  input  logic               mem_gnt_i,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic               mem_rvalid_i,
  input  logic [ADDR_W-1:0]  mem_rdata_i,
  output logic               done_o,
  output logic [ADDR_W-1:0]  paddr_o,
  output logic               fault_o,
  output logic [1:0]         fault_cause_o,
  output logic [ADDR_W-1:0]  fault_addr_o
);
  walk_st_e           state_q;
  logic [ADDR_W-1:0]  laddr_q;
  logic               wr_q, us_q;
  logic [FRAME_W-1:0] tbl_frame_q;
  logic               done_q, fault_q;
  logic [1:0]         cause_q;
  logic [ADDR_W-1:0]  paddr_q, faddr_q;

  logic [ADDR_W-1:0]  lvl_addr [LEVELS];
  logic [1:0]         ent_cause;
  logic               tbl_lvl;
  logic               unused_ent_bits;

  assign unused_ent_bits = ^mem_rdata_i[OFF_W-1:ENT_USER+1];

  // level 0 indexes the directory, level 1 the page table
  for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
    logic [FRAME_W-1:0] frame;
    if (g == 0) begin : g_dir
      assign frame = dir_frame_i;
    end else begin : g_tbl
      assign frame = tbl_frame_q;
    end
    pw_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
      .frame_i(frame),
      .idx_i  (laddr_q[OFF_W + (LEVELS-1-g)*IDX_W +: IDX_W]),
      .addr_o (lvl_addr[g])
    );
  end

  pw_perm_check u_perm (
    .present_i(mem_rdata_i[ENT_PRESENT]),
    .wr_ok_i  (mem_rdata_i[ENT_WRITE]),
    .user_ok_i(mem_rdata_i[ENT_USER]),
    .write_i  (wr_q),
    .user_i   (us_q),
    .cause_o  (ent_cause)
  );

  assign tbl_lvl     = (state_q == ST_TREQ) || (state_q == ST_TWAIT);
  assign mem_req_o   = (state_q == ST_DREQ) || (state_q == ST_TREQ);
  assign mem_addr_o  = tbl_lvl ? lvl_addr[1] : lvl_addr[0];
  assign req_ready_o = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      laddr_q     <= '0;
      wr_q        <= 1'b0;
      us_q        <= 1'b0;
      tbl_frame_q <= '0;
      done_q      <= 1'b0;
      fault_q     <= 1'b0;
      cause_q     <= FC_NONE;
      paddr_q     <= '0;
      faddr_q     <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          laddr_q <= req_laddr_i;
          wr_q    <= req_write_i;
          us_q    <= req_user_i;
          if (paging_en_i && prot_en_i) begin
            state_q <= ST_DREQ;
          end else begin
            done_q  <= 1'b1;
            paddr_q <= req_laddr_i;
          end
        end
        ST_DREQ: if (mem_gnt_i) state_q <= ST_DWAIT;
        ST_DWAIT: if (mem_rvalid_i) begin
          if (ent_cause != FC_NONE) begin
            fault_q <= 1'b1;
            cause_q <= ent_cause;
            faddr_q <= laddr_q;
            state_q <= ST_IDLE;
          end else begin
            tbl_frame_q <= mem_rdata_i[ADDR_W-1:OFF_W];
            state_q     <= ST_TREQ;
          end
        end
        ST_TREQ: if (mem_gnt_i) state_q <= ST_TWAIT;
        ST_TWAIT: if (mem_rvalid_i) begin
          state_q <= ST_IDLE;
          if (ent_cause != FC_NONE) begin
            fault_q <= 1'b1;
            cause_q <= ent_cause;
            faddr_q <= laddr_q;
          end else begin
            done_q  <= 1'b1;
            paddr_q <= {mem_rdata_i[ADDR_W-1:OFF_W], laddr_q[OFF_W-1:0]};
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o        = done_q;
  assign fault_o       = fault_q;
  assign fault_cause_o = cause_q;
  assign paddr_o       = paddr_q;
  assign fault_addr_o  = faddr_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              mem_req_o,
  input logic              mem_gnt_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              done_o,
  input logic              fault_o,
  input logic [1:0]        fault_cause_o,
  input logic [ADDR_W-1:0] fault_addr_o
);
  p_req_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  p_cause_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> fault_cause_o != 2'd0);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_fault_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);

  p_strobe_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));

  p_busy_no_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o);

  p_faddr_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |=> !fault_o |-> $stable(fault_addr_o));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_ready_o  (req_ready_o),
  .mem_req_o    (mem_req_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_addr_o   (mem_addr_o),
  .done_o       (done_o),
  .fault_o      (fault_o),
  .fault_cause_o(fault_cause_o),
  .fault_addr_o (fault_addr_o)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, req_user = 0, pg = 0, pe = 0;
  logic [31:0] req_laddr = 0;
  logic [19:0] dir_frame = 20'h00010;
  logic        gnt = 0, rvalid = 0;
  logic [31:0] rdata = 0;
  logic        req_ready, mem_req, done, fault;
  logic [31:0] mem_addr, paddr, faddr;
  logic [1:0]  cause;

  int checks = 0, fails = 0;
  bit exp_done = 0, exp_fault = 0, mon_en = 0;
  logic [31:0] last_fa = 0;
  int unsigned mem [int unsigned];

  always #2 clk = ~clk;

  pt_walker u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_laddr_i(req_laddr),
    .req_write_i(req_write), .req_user_i(req_user),
    .paging_en_i(pg), .prot_en_i(pe), .dir_frame_i(dir_frame),
    .mem_req_o(mem_req), .mem_gnt_i(gnt), .mem_addr_o(mem_addr),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
    .done_o(done), .paddr_o(paddr), .fault_o(fault),
    .fault_cause_o(cause), .fault_addr_o(faddr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [1:0] perm(input logic [31:0] e, input bit wr, input bit us);
    if (!e[0]) return 2'd1;
    if (wr && !e[1]) return 2'd2;
    if (us && !e[2]) return 2'd3;
    return 2'd0;
  endfunction

  // strobes compared with the model on every clock
  always @(negedge clk) if (mon_en) begin
    chk(done == exp_done, "R9 done strobe", 32'(done), 32'(exp_done));
    chk(fault == exp_fault, "R9 fault strobe", 32'(fault), 32'(exp_fault));
  end

  task automatic walk(input logic [31:0] la, input bit wr, input bit us, input bit p_en,
                      input bit m_en, input int gd, input int rdly, input bit poke, input string tg);
    bit ok_kind; logic [31:0] pa, e; logic [1:0] c; int nrd; logic [31:0] a [2];
    string t;
    ok_kind = 1; c = 0; nrd = 0; pa = la;
    if (p_en && m_en) begin
      a[0] = {dir_frame, 12'h0} + 32'(la[31:22]) * 4;
      e = rd(a[0]); nrd = 1; c = perm(e, wr, us);
      if (c == 0) begin
        a[1] = {e[31:12], 12'h0} + 32'(la[21:12]) * 4;
        e = rd(a[1]); nrd = 2; c = perm(e, wr, us);
        if (c == 0) pa = {e[31:12], la[11:0]};
      end
      ok_kind = (c == 0);
    end
    @(posedge clk); #1;
    chk(req_ready == 1'b1, "R9 ready idle", 32'(req_ready), 32'h1);
    req_valid = 1; req_laddr = la; req_write = wr; req_user = us; pg = p_en; pe = m_en;
    @(posedge clk); #1;
    req_valid = 0;
    for (int i = 0; i < nrd; i++) begin
      t = (i == 0) ? "R3" : "R4";
      chk(mem_req == 1'b1, t, 32'(mem_req), 32'h1);
      chk(mem_addr == a[i], t, mem_addr, a[i]);
      chk(req_ready == 1'b0, "R9 busy", 32'(req_ready), 32'h0);
      for (int k = 0; k < gd; k++) begin
        if (poke) begin req_valid = 1; req_laddr = 32'hDEADBEEF; end
        @(posedge clk); #1;
        req_valid = 0;
        chk(mem_req && mem_addr == a[i], "R3 hold", mem_addr, a[i]);
      end
      gnt = 1;
      @(posedge clk); #1;
      gnt = 0;
      chk(mem_req == 1'b0, "R3 drop", 32'(mem_req), 32'h0);
      for (int k = 0; k < rdly; k++) begin @(posedge clk); #1; end
      rvalid = 1; rdata = rd(a[i]);
      @(posedge clk); #1;
      rvalid = 0; rdata = 0;
    end
    if (nrd == 0) chk(mem_req == 1'b0, "R2 no read", 32'(mem_req), 32'h0);
    exp_done = ok_kind; exp_fault = !ok_kind;
    if (ok_kind) begin
      chk(paddr == pa, tg, paddr, pa);
      chk(faddr == last_fa, "R11", faddr, last_fa);
    end else begin
      t = (c == 1) ? "R6" : (c == 2) ? "R7" : "R8";
      chk(cause == c, t, 32'(cause), 32'(c));
      chk(faddr == la, "R6 fault addr", faddr, la);
      last_fa = la;
    end
    @(posedge clk); #1;
    exp_done = 0; exp_fault = 0;
    chk(req_ready == 1'b1, "R9 ready again", 32'(req_ready), 32'h1);
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R9 actual=hung expected=idle");
    finish_run();
  end

  initial begin
    // directory at 0x10000, tables at 0x20000 and 0x30000
    mem[32'h00010018] = 32'h000200A7;
    mem[32'h00020008] = 32'h123450A7;
    mem[32'h00020010] = 32'h00055005;
    mem[32'h00020014] = 32'h00066003;
    mem[32'h00020018] = 32'h00044001;
    mem[32'h00010020] = 32'h00020005;
    mem[32'h00020000] = 32'h00077007;
    mem[32'h00010FFC] = 32'h00030007;
    mem[32'h00030FFC] = 32'h0ABCD007;

    repeat (3) @(posedge clk); #1;
    chk(done == 0, "R1 done", 32'(done), 0);
    chk(fault == 0, "R1 fault", 32'(fault), 0);
    chk(mem_req == 0, "R1 mem_req", 32'(mem_req), 0);
    chk(req_ready == 1, "R1 ready", 32'(req_ready), 1);
    chk(faddr == 0, "R1 fault addr", faddr, 0);
    rst_n = 1; mon_en = 1;

    walk(32'h01802038, 0, 0, 1, 1, 0, 0, 0, "R5 R10");
    walk(32'h01802038, 1, 1, 0, 1, 0, 0, 0, "R2 pg off");
    walk(32'h00ABC123, 0, 0, 1, 0, 0, 0, 0, "R2 pe off");
    walk(32'h01C02038, 0, 0, 1, 1, 1, 1, 0, "R6");
    walk(32'h01803123, 0, 0, 1, 1, 0, 2, 0, "R6");
    walk(32'h01804FFF, 1, 0, 1, 1, 2, 0, 0, "R7");
    walk(32'h01804FFF, 0, 1, 1, 1, 0, 0, 0, "R5 R11");
    walk(32'h02000010, 1, 0, 1, 1, 0, 0, 0, "R7");
    walk(32'h02000010, 0, 1, 1, 1, 0, 1, 0, "R5");
    walk(32'h01805000, 0, 1, 1, 1, 0, 0, 0, "R8");
    walk(32'h01806000, 1, 1, 1, 1, 1, 0, 0, "R8");
    walk(32'hFFFFFFFF, 1, 1, 1, 1, 3, 2, 1, "R5 R9");
    walk(32'h01802FFF, 1, 1, 1, 1, 2, 3, 1, "R5 R11");

    mon_en = 0;
    finish_run();
  end
endmodule